// File: doc/BRIEF.md
# Two-Instruction RV64 Execute Unit

This block runs one 32-bit instruction word at a time. It recognises exactly two encodings. The first is an add of a sign-extended 12-bit immediate to a register. The second is a 64-bit load from a register plus a sign-extended offset. Any other word is refused and changes no state. The block holds thirty-two 64-bit integer registers and a program counter. Register zero always reads as zero.

Instructions arrive on a valid/ready stream. A word is consumed on a rising edge where `insn_valid` and `insn_ready` are both high. While a load waits for its data, `insn_ready` stays low, and the producer must hold the word until it is taken. The load goes out on a read port. `mem_req` and `mem_addr` stay asserted and stable until the responder raises `mem_rdata_valid` for one cycle with the data. Every retired register write shows on a one-cycle writeback pulse, so the surrounding logic can trace the architectural effect of each instruction.

Top module: `mx_exec`

## Requirements
- R1: After reset, `pc_out` is 0, every register reads 0, and `mem_req`, `wb_valid`, `illegal_insn` and `busy` are low while `insn_ready` is high.
- R2: Register 0 always supplies zero as a source. A write aimed at register 0 is dropped and leaves it at zero, though the writeback pulse still reports the computed value.
- R3: A word with bits [6:0]=0010011 and bits [14:12]=000 adds register[bits 19:15] to the sign-extended immediate in bits [31:20] and writes the sum to register[bits 11:7]. In the cycle after acceptance, `wb_valid` is 1 with `wb_idx`=rd and `wb_data`=sum.
- R4: The add wraps modulo 2^64.
- R5: A word with bits [6:0]=0000011 and bits [14:12]=011 has the same field positions. In the cycle after acceptance, `mem_req` rises with `mem_addr` = rs1 + sign-extended immediate. Both hold unchanged until the cycle in which `mem_rdata_valid` is high.
- R6: On the cycle with `mem_rdata_valid` high during a pending load, `mem_rdata` is written to rd. In the next cycle, `wb_valid` is 1 with that data and `mem_req` is low.
- R7: Any other word raises `illegal_insn` for exactly the cycle after acceptance. It writes no register, raises no `mem_req` and produces no writeback.
- R8: From the acceptance of a load until its data returns, `insn_ready` is low and `busy` is high. A word presented in that window is not consumed, and it is executed only after the load completes.
- R9: `pc_out` advances by 4 for each instruction. For an add or a refused word, it advances on the acceptance edge. For a load, it advances on the edge where its data returns.
- R10: When rd equals rs1, the source value is the one held before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Block can take a word this cycle |
| insn_word | input | 32 | Instruction word |
| illegal_insn | output | 1 | One-cycle pulse: word refused |
| busy | output | 1 | Load outstanding |
| mem_req | output | 1 | Read request, held until data returns |
| mem_addr | output | 64 | Read byte address |
| mem_rdata_valid | input | 1 | Read data present |
| mem_rdata | input | 64 | Read data |
| wb_valid | output | 1 | One-cycle pulse: register write retired |
| wb_idx | output | 5 | Destination register of the retired write |
| wb_data | output | 64 | Value of the retired write |
| pc_out | output | 64 | Current program counter |

## Verification
The bench covers several faults:
- Negative immediates and the largest positive one. A design that zero-extends gives a wrong sum or a wrong load address.
- An all-ones register incremented by one. A design that saturates, or keeps a carry, fails to read back zero.
- A similar opcode with the wrong function field, and the all-zero word. A decoder that ignores bits [14:12] would run or load where it must refuse.
- Writes to register 0 from both the add and the load, each read back through a later add.
- An instruction held on the stream during a load wait. A design that ignores back-pressure would retire it before the load and with stale data.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam int ILEN = 32;
  localparam int IMMW = 12;
  localparam int RIDXW = 5;

  localparam logic [6:0] OPC_ADDI = 7'b0010011;
  localparam logic [2:0] F3_ADDI  = 3'b000;
  localparam logic [6:0] OPC_LD   = 7'b0000011;
  localparam logic [2:0] F3_LD    = 3'b011;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADDI = 2'd1,
    OP_LD   = 2'd2
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [RIDXW-1:0] rd;
    logic [RIDXW-1:0] rs1;
    logic [IMMW-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/mx_decode.sv
module mx_decode
  import mx_pkg::*;
(
  input  logic [ILEN-1:0] word,
  output dec_t            dec
);
  logic [6:0] opc;
  logic [2:0] f3;

  always_comb begin
    opc     = word[6:0];
    f3      = word[14:12];
    dec.rd  = word[11:7];
    dec.rs1 = word[19:15];
    dec.imm = word[31:20];
    if (opc == OPC_ADDI && f3 == F3_ADDI)
      dec.op = OP_ADDI;
    else if (opc == OPC_LD && f3 == F3_LD)
      dec.op = OP_LD;
    else
      dec.op = OP_NONE;
  end
endmodule

// File: rtl/mx_regfile.sv
module mx_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   rs_idx,
  output logic [XLEN-1:0] rs_data,
  input  logic            we,
  input  logic [IW-1:0]   wd_idx,
  input  logic [XLEN-1:0] wd_data
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (we && wd_idx == IW'(g))
          regs[g] <= wd_data;
      end
    end
  end

  assign rs_data = regs[rs_idx];

  // A write to any nonzero register is visible on the next read of it.
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wd_idx != '0 && rs_idx == wd_idx) |=>
      (rs_idx != $past(wd_idx)) || (rs_data == $past(wd_data)));
endmodule

// File: rtl/mx_exec.sv
module mx_exec
  import mx_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [31:0]     insn_word,
  output logic            illegal_insn,
  output logic            busy,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_rdata_valid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            wb_valid,
  output logic [IW-1:0]   wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] pc_out
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  dec_t            dec;
  logic [XLEN-1:0] rs_data;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] sum;
  logic            pend_q;
  logic [IW-1:0]   pend_rd_q;
  logic [XLEN-1:0] addr_q;
  logic [XLEN-1:0] pc_q;
  logic            wb_valid_q;
  logic [IW-1:0]   wb_idx_q;
  logic [XLEN-1:0] wb_data_q;
  logic            illegal_q;
  logic            accept;
  logic            load_done;
  logic            rf_we;
  logic [IW-1:0]   rf_widx;
  logic [XLEN-1:0] rf_wdata;

  mx_decode u_dec (
    .word (insn_word),
    .dec  (dec)
  );

  mx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rs_idx  (IW'(dec.rs1)),
    .rs_data (rs_data),
    .we      (rf_we),
    .wd_idx  (rf_widx),
    .wd_data (rf_wdata)
  );

  assign imm_ext   = {{(XLEN-IMMW){dec.imm[IMMW-1]}}, dec.imm};
  assign sum       = rs_data + imm_ext;
  assign accept    = insn_valid && !pend_q;
  assign load_done = pend_q && mem_rdata_valid;

  always_comb begin
    rf_we    = load_done || (accept && dec.op == OP_ADDI);
    rf_widx  = pend_q ? pend_rd_q : IW'(dec.rd);
    rf_wdata = pend_q ? mem_rdata : sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_rd_q  <= '0;
      addr_q     <= '0;
      pc_q       <= '0;
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
      wb_data_q  <= '0;
      illegal_q  <= 1'b0;
    end else begin
      wb_valid_q <= 1'b0;
      illegal_q  <= 1'b0;
      if (load_done) begin
        pend_q     <= 1'b0;
        wb_valid_q <= 1'b1;
        wb_idx_q   <= pend_rd_q;
        wb_data_q  <= mem_rdata;
        pc_q       <= pc_q + PC_STEP;
      end else if (accept) begin
        unique case (dec.op)
          OP_ADDI: begin
            wb_valid_q <= 1'b1;
            wb_idx_q   <= IW'(dec.rd);
            wb_data_q  <= sum;
            pc_q       <= pc_q + PC_STEP;
          end
          OP_LD: begin
            pend_q    <= 1'b1;
            pend_rd_q <= IW'(dec.rd);
            addr_q    <= sum;
          end
          default: begin
            illegal_q <= 1'b1;
            pc_q      <= pc_q + PC_STEP;
          end
        endcase
      end
    end
  end

  assign insn_ready   = !pend_q;
  assign busy         = pend_q;
  assign mem_req      = pend_q;
  assign mem_addr     = addr_q;
  assign wb_valid     = wb_valid_q;
  assign wb_idx       = wb_idx_q;
  assign wb_data      = wb_data_q;
  assign illegal_insn = illegal_q;
  assign pc_out       = pc_q;

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdata_valid) |=> (mem_req && $stable(mem_addr)));

  assert_req_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(insn_valid && insn_ready && dec.op == OP_LD));

  assert_refuse_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_insn |-> (!mem_req && !wb_valid));

  assert_load_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rdata_valid) |=> (!mem_req && wb_valid && wb_data == $past(mem_rdata)));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || illegal_insn) |-> (pc_out == $past(pc_out) + PC_STEP));

  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdata_valid) |=> !insn_ready);
endmodule

// File: tb/mx_exec_tb.sv
module mx_exec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  function automatic logic [31:0] enc_addi(input int rd, input int rs, input logic [11:0] imm);
    return {imm, 5'(rs), 3'b000, 5'(rd), 7'b0010011};
  endfunction

  function automatic logic [31:0] enc_ld(input int rd, input int rs, input logic [11:0] imm);
    return {imm, 5'(rs), 3'b011, 5'(rd), 7'b0000011};
  endfunction

  // {word, refused, expected writeback}
  localparam logic [96:0] VEC [NVEC] = '{
    {enc_addi(1, 0, 12'd5),   1'b0, 64'd5},
    {enc_addi(2, 1, 12'hFFF), 1'b0, 64'd4},
    {enc_addi(1, 1, 12'h7FF), 1'b0, 64'd2052},                    // R10 rd==rs1
    {enc_addi(0, 1, 12'd9),   1'b0, 64'd2061},                    // R2 write to x0
    {enc_addi(3, 0, 12'd0),   1'b0, 64'd0},                       // R2 x0 still zero
    {{12'd1, 5'd1, 3'b100, 5'd3, 7'b0010011}, 1'b1, 64'd0},       // R7 other funct3
    {enc_addi(3, 3, 12'd0),   1'b0, 64'd0},
    {32'h0000_0000,           1'b1, 64'd0},
    {{12'd0, 5'd1, 3'b010, 5'd3, 7'b0000011}, 1'b1, 64'd0},       // R7 narrower load
    {enc_addi(4, 0, 12'h800), 1'b0, 64'hFFFF_FFFF_FFFF_F800},
    {enc_addi(6, 0, 12'hFFF), 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {enc_addi(6, 6, 12'd1),   1'b0, 64'd0},                       // R4 wrap
    {enc_addi(3, 3, 12'd0),   1'b0, 64'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn_word = '0;
  logic        illegal_insn;
  logic        busy;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rdata_valid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic [63:0] pc_out;

  int n_total = 0;
  int n_bad = 0;
  logic [63:0] pc_exp = '0;
  bit done = 1'b0;

  mx_exec u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .illegal_insn(illegal_insn), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata_valid(mem_rdata_valid),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data), .pc_out(pc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] w, input bit refused, input logic [63:0] data);
    @(negedge clk);
    insn_valid = 1'b1;
    insn_word  = w;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    pc_exp += 64'd4;
    chk(refused ? "R7 illegal pulse" : "R3 illegal low", 64'(illegal_insn), 64'(refused));
    chk(refused ? "R7 no writeback" : "R3 writeback", 64'(wb_valid), 64'(!refused));
    chk("R7 no request", 64'(mem_req), 64'd0);
    if (!refused) begin
      chk("R3 data", wb_data, data);
      chk("R3 rd", 64'(wb_idx), 64'(w[11:7]));
    end
    chk("R9 pc", pc_out, pc_exp);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pc", pc_out, 64'd0);
    chk("R1 req", 64'(mem_req), 64'd0);
    chk("R1 wb", 64'(wb_valid), 64'd0);
    chk("R1 ready", 64'(insn_ready), 64'd1);
    chk("R1 busy", 64'(busy), 64'd0);

    for (int i = 0; i < NVEC; i++)
      run_one(VEC[i][96:65], VEC[i][64], VEC[i][63:0]);

    // R5 / R6 / R8: load with a word waiting behind it
    @(negedge clk);
    insn_valid = 1'b1;
    insn_word  = enc_ld(7, 1, 12'd8);
    @(posedge clk);
    @(negedge clk);
    insn_word = enc_addi(8, 7, 12'd0);
    chk("R5 req", 64'(mem_req), 64'd1);
    chk("R5 addr", mem_addr, 64'd2060);
    chk("R8 ready low", 64'(insn_ready), 64'd0);
    chk("R8 busy", 64'(busy), 64'd1);
    chk("R9 pc hold", pc_out, pc_exp);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R5 req held", 64'(mem_req), 64'd1);
      chk("R5 addr held", mem_addr, 64'd2060);
      chk("R8 not consumed", 64'(wb_valid), 64'd0);
    end
    mem_rdata_valid = 1'b1;
    mem_rdata = 64'h0123_4567_89AB_CDEF;
    @(posedge clk);
    @(negedge clk);
    mem_rdata_valid = 1'b0;
    pc_exp += 64'd4;
    chk("R6 wb", 64'(wb_valid), 64'd1);
    chk("R6 idx", 64'(wb_idx), 64'd7);
    chk("R6 data", wb_data, 64'h0123_4567_89AB_CDEF);
    chk("R6 req drop", 64'(mem_req), 64'd0);
    chk("R9 pc load", pc_out, pc_exp);
    chk("R8 ready back", 64'(insn_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    pc_exp += 64'd4;
    chk("R8 held word runs", 64'(wb_valid), 64'd1);
    chk("R8 sees load data", wb_data, 64'h0123_4567_89AB_CDEF);
    chk("R8 idx", 64'(wb_idx), 64'd8);

    // R5 negative offset, load into x0 (R2)
    @(negedge clk);
    insn_valid = 1'b1;
    insn_word  = enc_ld(0, 0, 12'hFF8);
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    chk("R5 neg addr", mem_addr, 64'hFFFF_FFFF_FFFF_FFF8);
    mem_rdata_valid = 1'b1;
    mem_rdata = 64'h55;
    @(posedge clk);
    @(negedge clk);
    mem_rdata_valid = 1'b0;
    pc_exp += 64'd4;
    chk("R6 wb x0", 64'(wb_valid), 64'd1);
    run_one(enc_addi(10, 0, 12'd0), 1'b0, 64'd0);   // R2 load to x0 dropped

    // R1: reset mid-run clears registers and pc
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    pc_exp = '0;
    chk("R1 pc after reset", pc_out, 64'd0);
    chk("R1 ready after reset", 64'(insn_ready), 64'd1);
    run_one(enc_addi(11, 1, 12'd0), 1'b0, 64'd0);   // R1 x1 cleared

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule